// File: doc/BRIEF.md
# H-Bridge Fault Protection Controller

This block supervises the power stage of a driver built from two half-bridges. It takes digitized comparator flags as inputs: supply undervoltage, charge-pump undervoltage, one overcurrent flag per half-bridge, and over-temperature. From these it decides each cycle whether each half-bridge gate may follow its drive request. It also drives an active-low fault indication and the charge-pump enable. The flags arrive asynchronously and are resynchronized inside the block. The only timing counted inside the block is the overcurrent deglitch and the retry interval.

Supply, charge-pump and thermal faults shut the whole stage down, and the stage recovers on its own when the flag clears. The response to overcurrent is chosen with a mode input. In retry mode the block shuts the stage off for a timed interval and then tries again. In latched mode it stays off until the sleep input is pulsed low or the block is reset. A second mode input lets each half-bridge trip on its own overcurrent. In that mode both half-bridges share one retry timer.

Top module: `hbridge_fault_ctrl`

## Requirements
- R1: While the supply undervoltage flag is active, both gates and the charge-pump enable are low and fault_n is low. All three return to normal without intervention when the flag clears.
- R2: While the charge-pump undervoltage flag is active, both gates are low and fault_n is low, and cp_en stays high. The block recovers on its own when the flag clears.
- R3: An overcurrent trips only if the synchronized flag is high for more than DEGLITCH_CYC consecutive cycles. A flag raised at the inputs for DEGLITCH_CYC+1 edges removes the gates after edge DEGLITCH_CYC+3. A flag held for only DEGLITCH_CYC edges has no effect.
- R4: In retry mode (retry_mode=1) a tripped stage stays off with fault_n low for RETRY_CYC cycles. It then follows drive_req again. If the overcurrent persists, the stage trips again after the deglitch interval.
- R5: In latched mode (retry_mode=0) a tripped stage stays off with fault_n low until sleep_n is sampled low or rst_n is asserted.
- R6: In independent mode (indep_mode=1) an overcurrent on half-bridge i clears only hb_en[i] and drives fault_n low. If both half-bridges trip, both gates are cleared. With indep_mode=0, any trip clears both gates.
- R7: In independent retry mode, if the second half-bridge trips while the retry interval is running, the interval restarts at its full length. Both half-bridges re-enable together when it ends.
- R8: While the over-temperature flag is active, both gates are low, fault_n is low and cp_en stays high. The block recovers on its own when the flag clears.
- R9: fault_n is high only when no fault flag is active and no overcurrent off state is pending.
- R10: A supply, charge-pump or thermal fault clears the deglitch counters and the retry timer, and in retry mode it also clears a pending overcurrent off state. The stage therefore resumes as soon as that fault clears, without waiting for the rest of the retry interval.
- R11: hb_en[i] is high only when drive_req[i] is high and the half-bridge is otherwise enabled. While rst_n or sleep_n is low, both gates and cp_en are low.
- R12: A change on a fault flag input reaches the outputs after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleep_n | input | 1 | Active-low sleep; a low sample clears a latched overcurrent |
| retry_mode | input | 1 | 1: automatic retry, 0: latched overcurrent response |
| indep_mode | input | 1 | 1: half-bridges trip independently on overcurrent |
| drive_req | input | 2 | Requested enable for each half-bridge |
| uv_supply_a | input | 1 | Asynchronous supply undervoltage flag |
| uv_pump_a | input | 1 | Asynchronous charge-pump undervoltage flag |
| oc_a | input | 2 | Asynchronous overcurrent flag per half-bridge |
| ot_a | input | 1 | Asynchronous over-temperature flag |
| hb_en | output | 2 | Gate enable for each half-bridge |
| fault_n | output | 1 | Active-low fault indication |
| cp_en | output | 1 | Charge-pump enable |

## Verification
A wrong overcurrent off state shows up at the ports within one cycle: either a gate stays enabled while fault_n is low, or fault_n stays low with no flag active. A wrong deglitch or retry count moves the edge at which hb_en falls or rises by one or more cycles. The bench therefore samples the gates on the exact edge where they are expected to change, not after a margin. A wrong restart of the shared retry timer shows as the first half-bridge coming back six cycles early.

// File: rtl/hbridge_fault_ctrl.sv
module hbridge_fault_ctrl #(
  parameter int DEGLITCH_CYC = 32,
  parameter int RETRY_CYC    = 3000,
  localparam int DW = $clog2(DEGLITCH_CYC + 1),
  localparam int RW = $clog2(RETRY_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n,
  input  logic       retry_mode,
  input  logic       indep_mode,
  input  logic [1:0] drive_req,
  input  logic       uv_supply_a,
  input  logic       uv_pump_a,
  input  logic [1:0] oc_a,
  input  logic       ot_a,
  output logic [1:0] hb_en,
  output logic       fault_n,
  output logic       cp_en
);

  logic [4:0] meta_q, sync_q;
  logic       uv_s, cp_s, ot_s, hold_all;
  logic [1:0] oc_s, trip, hit, oc_off;
  logic [RW-1:0] retry_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {ot_a, oc_a, uv_pump_a, uv_supply_a};
      sync_q <= meta_q;
    end
  end

  assign uv_s     = sync_q[0];
  assign cp_s     = sync_q[1];
  assign oc_s     = sync_q[3:2];
  assign ot_s     = sync_q[4];
  assign hold_all = uv_s | cp_s | ot_s;

  for (genvar i = 0; i < 2; i++) begin : g_deglitch
    logic [DW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt <= '0;
      else if (hold_all || !sleep_n || oc_off[i] || !oc_s[i])
        cnt <= '0;
      else if (cnt != DW'(DEGLITCH_CYC))
        cnt <= cnt + DW'(1);
    end
    assign trip[i] = oc_s[i] & ~oc_off[i] & ~hold_all & sleep_n &
                     (cnt == DW'(DEGLITCH_CYC));
  end

  assign hit = indep_mode ? trip : {2{|trip}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      oc_off <= '0;
    else if (!sleep_n || (hold_all && retry_mode))
      oc_off <= '0;
    else if (|trip)
      oc_off <= oc_off | hit;
    else if (retry_mode && retry_cnt == RW'(1))
      oc_off <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      retry_cnt <= '0;
    else if (!sleep_n || hold_all)
      retry_cnt <= '0;
    else if ((|trip) && retry_mode)
      retry_cnt <= RW'(RETRY_CYC);
    else if (retry_cnt != '0)
      retry_cnt <= retry_cnt - RW'(1);
  end

  assign hb_en   = {2{rst_n & sleep_n & ~hold_all}} & ~oc_off & drive_req;
  assign fault_n = ~(hold_all | (|oc_off));
  assign cp_en   = rst_n & sleep_n & ~uv_s;

endmodule

module hbridge_fault_chk #(
  parameter int RETRY_CYC = 3000,
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_n,
  input logic          retry_mode,
  input logic          uv_s,
  input logic          cp_s,
  input logic          ot_s,
  input logic          hold_all,
  input logic [1:0]    trip,
  input logic [1:0]    oc_off,
  input logic [RW-1:0] retry_cnt,
  input logic [1:0]    hb_en,
  input logic          fault_n,
  input logic          cp_en
);

  assert_supply_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |-> (hb_en == 2'b00 && !cp_en && !fault_n));

  assert_pump_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cp_s |-> (hb_en == 2'b00 && !fault_n));

  assert_temp_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |-> (hb_en == 2'b00 && !fault_n));

  assert_pending_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_off != 2'b00) |-> !fault_n);

  assert_latch_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!retry_mode && sleep_n && oc_off != 2'b00) |=>
      ((oc_off & $past(oc_off)) == $past(oc_off)));

  assert_timer_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_mode && sleep_n && !hold_all && trip != 2'b00) |=>
      (retry_cnt == RW'(RETRY_CYC)));

  assert_gate_off_when_tripped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hb_en & oc_off) == 2'b00));

endmodule

bind hbridge_fault_ctrl hbridge_fault_chk #(.RETRY_CYC(RETRY_CYC), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .retry_mode(retry_mode),
  .uv_s(uv_s), .cp_s(cp_s), .ot_s(ot_s), .hold_all(hold_all),
  .trip(trip), .oc_off(oc_off), .retry_cnt(retry_cnt),
  .hb_en(hb_en), .fault_n(fault_n), .cp_en(cp_en)
);

// File: tb/hbridge_fault_ctrl_tb.sv
module hbridge_fault_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEG = 3;
  localparam int RET = 8;

  logic clk = 0, rst_n = 0, sleep_n = 1, retry_mode = 1, indep_mode = 0;
  logic [1:0] drive_req = 2'b11, oc_a = 2'b00;
  logic uv_supply_a = 0, uv_pump_a = 0, ot_a = 0;
  logic [1:0] hb_en;
  logic fault_n, cp_en;
  int checks = 0, fails = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_fault_ctrl #(.DEGLITCH_CYC(DEG), .RETRY_CYC(RET)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .retry_mode(retry_mode),
    .indep_mode(indep_mode), .drive_req(drive_req), .uv_supply_a(uv_supply_a),
    .uv_pump_a(uv_pump_a), .oc_a(oc_a), .ot_a(ot_a),
    .hb_en(hb_en), .fault_n(fault_n), .cp_en(cp_en));

  // {tag[3:0], uv, pump, ot, sleep_n, drive[1:0], exp_hb[1:0], exp_fault_n, exp_cp}
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    14'b1011_0001_11_11_1_1, // R11 full drive
    14'b1011_0001_01_01_1_1, // R11 one side requested
    14'b0001_1001_11_00_0_0, // R1 supply low
    14'b0001_0001_11_11_1_1, // R1 resume
    14'b0010_0101_11_00_0_1, // R2 pump low
    14'b0010_0001_10_10_1_1, // R2 resume
    14'b1000_0011_11_00_0_1, // R8 hot
    14'b1000_0001_11_11_1_1, // R8 resume
    14'b1001_1111_11_00_0_0, // R9 all flags
    14'b1011_0000_11_00_1_0, // R11 sleep
    14'b1001_0001_11_11_1_1  // R9 clear again
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [1:0] e_hb, input logic e_fn, input logic e_cp);
    checks++;
    if (hb_en !== e_hb || fault_n !== e_fn || cp_en !== e_cp) begin
      fails++;
      $display("FAIL %s: hb_en=%b fault_n=%b cp_en=%b expected hb_en=%b fault_n=%b cp_en=%b",
               tag, hb_en, fault_n, cp_en, e_hb, e_fn, e_cp);
    end
  endtask

  task automatic clean();
    oc_a = 2'b00; uv_supply_a = 0; uv_pump_a = 0; ot_a = 0;
    sleep_n = 0;
    tick(3);
    sleep_n = 1;
    tick(1);
  endtask

  initial begin
    tick(2);
    chk("R11 reset", 2'b00, 1'b1, 1'b0);
    rst_n = 1;
    tick(1);
    for (int i = 0; i < NV; i++) begin
      uv_supply_a = VEC[i][9]; uv_pump_a = VEC[i][8]; ot_a = VEC[i][7];
      sleep_n = VEC[i][6]; drive_req = VEC[i][5:4];
      tick(3);
      chk($sformatf("R%0d vector %0d", VEC[i][13:10], i), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end
    drive_req = 2'b11;
    clean();

    // R12 two-edge latency
    uv_supply_a = 1; tick(1);
    chk("R12 one edge", 2'b11, 1'b1, 1'b1);
    tick(1);
    chk("R12 two edges", 2'b00, 1'b0, 1'b0);
    uv_supply_a = 0; tick(2);
    chk("R12 release", 2'b11, 1'b1, 1'b1);
    clean();

    // R3 short pulse ignored
    oc_a = 2'b01; tick(DEG); oc_a = 2'b00; tick(6);
    chk("R3 short pulse", 2'b11, 1'b1, 1'b1);
    clean();

    // R3/R4/R6 common mode trip and retry
    oc_a = 2'b01; tick(DEG + 2);
    chk("R3 before trip", 2'b11, 1'b1, 1'b1);
    tick(1);
    chk("R6 common trip both off", 2'b00, 1'b0, 1'b1);
    oc_a = 2'b00; tick(RET - 1);
    chk("R4 still off", 2'b00, 1'b0, 1'b1);
    tick(1);
    chk("R4 retry end", 2'b11, 1'b1, 1'b1);
    clean();

    // R4 persistent overcurrent repeats
    oc_a = 2'b10; tick(DEG + 3);
    chk("R4 first trip", 2'b00, 1'b0, 1'b1);
    tick(RET);
    chk("R4 re-enable", 2'b11, 1'b1, 1'b1);
    tick(DEG);
    chk("R4 before repeat", 2'b11, 1'b1, 1'b1);
    tick(1);
    chk("R4 repeat trip", 2'b00, 1'b0, 1'b1);
    clean();

    // R5 latched
    retry_mode = 0;
    oc_a = 2'b01; tick(DEG + 3);
    chk("R5 trip", 2'b00, 1'b0, 1'b1);
    oc_a = 2'b00; tick(3 * RET);
    chk("R5 held", 2'b00, 1'b0, 1'b1);
    sleep_n = 0; tick(1);
    chk("R5 sleep", 2'b00, 1'b1, 1'b0);
    sleep_n = 1; tick(1);
    chk("R5 released", 2'b11, 1'b1, 1'b1);
    retry_mode = 1;
    clean();

    // R6/R7 independent with shared timer restart
    indep_mode = 1;
    oc_a = 2'b01; tick(DEG + 3);
    chk("R6 one side off", 2'b10, 1'b0, 1'b1);
    oc_a = 2'b10; tick(DEG + 2);
    chk("R6 other still on", 2'b10, 1'b0, 1'b1);
    tick(1);
    chk("R6 both off", 2'b00, 1'b0, 1'b1);
    oc_a = 2'b00; tick(RET - 1);
    chk("R7 timer restarted", 2'b00, 1'b0, 1'b1);
    tick(1);
    chk("R7 both back together", 2'b11, 1'b1, 1'b1);
    clean();
    oc_a = 2'b11; tick(DEG + 3);
    chk("R6 simultaneous", 2'b00, 1'b0, 1'b1);
    indep_mode = 0;
    clean();

    // R10 supply fault cancels pending retry
    oc_a = 2'b01; tick(DEG + 3);
    chk("R10 tripped", 2'b00, 1'b0, 1'b1);
    oc_a = 2'b00; uv_supply_a = 1; tick(2);
    chk("R10 supply low", 2'b00, 1'b0, 1'b0);
    uv_supply_a = 0; tick(2);
    chk("R10 early resume", 2'b11, 1'b1, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule